// File: doc/BRIEF.md
# Tiled Depth/Stencil Pixel Access Unit

This block turns single-pixel depth or stencil requests into accesses on a 32-bit synchronous memory port. A request gives window-relative pixel coordinates, the window origin, the surface pitch in pixels, and four mode bits. The mode bits choose the pixel format (a 16-bit depth word, or a packed 32-bit word holding 24 depth bits and 8 stencil bits), which end of that word holds the depth field, whether the stencil or the depth field is the target, and whether the surface is tiled. The block adds the origin to the coordinates and then forms a byte address. That address is either plain linear or tiled, with XOR bit swizzling inside the tile.

In the packed 32-bit format a write must leave the other field of the word untouched. The unit therefore reads the whole word, merges the new field in, and writes the word back. During that sequence it holds its request input not-ready, so the next request to the same word always sees the merged value. In the 16-bit format a write is one byte-enabled half-word store and needs no merge. A read returns the selected field right-aligned on a one-cycle response pulse.

Top module: `zs_access_unit`

## Requirements
- R1: In linear mode (req_tiled=0) the byte address on mem_addr is bpp*(X + Y*pitch). Here bpp is 4 when req_fmt32=1 and 2 when req_fmt32=0. X and Y are the absolute coordinates defined in R2.
- R2: The absolute coordinates used for every address are X = req_x + org_x and Y = req_y + org_y.
- R3: In tiled 32-bit mode the block number is B = (Y/16)*(pitch/16) + X/16 (with parameter NARROW_TILE=1, every 16 becomes 8). The address bits are: [1:0]=0, [4:2]=X[2:0], [6:5]=Y[1:0], [7]=X[4]^Y[2], [9:8]=B[1:0], [10]=Y[3], [11]=X[3]^Y[4], and bits 12 and up = B>>2.
- R4: In tiled 16-bit mode the block number is B = (Y/16)*(pitch/32) + X/32. The address bits are: [0]=0, [3:1]=X[2:0], [6:4]=Y[2:0], [7]=X[3], [9:8]=B[1:0], [10]=Y[3], [11]=X[4]^Y[4], and bits 12 and up = B>>2.
- R5: In the 32-bit format, req_order_hi=0 places depth in word bits 23:0 and stencil in bits 31:24. req_order_hi=1 places depth in bits 31:8 and stencil in bits 7:0.
- R6: A 32-bit write (req_tgt_stencil=0 for depth, 1 for stencil) is one read of the word (mem_be=4'hF) followed by one write of the whole word to the same address. The write carries the new field from req_wdata, right-aligned, and keeps every other bit as read.
- R7: A read raises rsp_valid for exactly one cycle. rsp_data carries the selected field right-aligned and zero-extended: 24 bits for depth, 8 for stencil, and 16 in the 16-bit format.
- R8: A 16-bit access is a single memory transaction. mem_be is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. A write sends req_wdata[15:0] in both halves of mem_wdata. req_wdata[23:16] has no effect.
- R9: req_ready falls the cycle after a request is accepted and stays low until that access has finished. A request issued right after a write to the same word reads the written value.
- R10: While mem_req is high and mem_ready is low, mem_req, mem_we, mem_addr and mem_wdata hold steady into the next cycle.
- R11: After reset, req_ready is 1, and mem_req and rsp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Pixel request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tgt_stencil | input | 1 | 1 = stencil field, 0 = depth field |
| req_fmt32 | input | 1 | 1 = packed 24+8 word, 0 = 16-bit depth |
| req_order_hi | input | 1 | 1 = depth in the upper 24 bits |
| req_tiled | input | 1 | 1 = tiled address, 0 = linear |
| req_x | input | CW | Window-relative x |
| req_y | input | CW | Window-relative y |
| org_x | input | CW | Window origin x |
| org_y | input | CW | Window origin y |
| req_pitch | input | PW | Surface pitch in pixels |
| req_wdata | input | 24 | Write value, right-aligned |
| rsp_valid | output | 1 | Read result pulse |
| rsp_data | output | 24 | Read result, right-aligned |
| mem_req | output | 1 | Memory transaction request |
| mem_ready | input | 1 | Memory accepts the transaction |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write word |
| mem_rvalid | input | 1 | Read word returned |
| mem_rdata | input | 32 | Read word |

## Verification
The bench hits coordinates whose bits 2, 3 and 4 differ between X and Y, so the XOR swizzle bits go both ways. A unit that swapped or dropped a swizzle term, or forgot the origin, would put the request on a different address than the scoreboard expects. Depth and stencil writes go back-to-back to the same word in both field orders and are then read back. A merge that clobbered the neighbouring field, or let the next request in before the write-back, would return stale or damaged values. Both 16-bit halves of a word are written with garbage in req_wdata[23:16], which catches a wrong byte enable or a leak of the high bits. The memory model withdraws mem_ready at irregular times, so any request that changed while stalled is caught.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam int WORD_W  = 32;
  localparam int DEPTH_W = 24;
  localparam int STEN_W  = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD    = 2'd1,
    ST_RWAIT = 2'd2,
    ST_WR    = 2'd3
  } zs_state_e;
endpackage

// File: rtl/zs_addr_gen.sv
module zs_addr_gen #(
  parameter int CW          = 12,
  parameter int PW          = 12,
  parameter int AW          = 32,
  parameter bit NARROW_TILE = 1'b0
) (
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] ox,
  input  logic [CW-1:0] oy,
  input  logic [PW-1:0] pitch,
  input  logic          fmt32,
  input  logic          tiled,
  output logic [AW-1:0] addr
);
  localparam int BW = AW - 10;  // block number width feeding bits 12 and up

  logic [AW-1:0] fx, fy, pw, lin_pix;
  logic [BW-1:0] blk32, blk16;
  logic [AW-1:0] t32, t16, lin;

  assign fx = AW'(x) + AW'(ox);
  assign fy = AW'(y) + AW'(oy);
  assign pw = AW'(pitch);

  assign lin_pix = fx + fy * pw;
  assign lin     = fmt32 ? (lin_pix << 2) : (lin_pix << 1);

  generate
    if (NARROW_TILE) begin : g_blk8
      assign blk32 = BW'(BW'(fy >> 3) * BW'(pw >> 3)) + BW'(fx >> 3);
    end else begin : g_blk16
      assign blk32 = BW'(BW'(fy >> 4) * BW'(pw >> 4)) + BW'(fx >> 4);
    end
  endgenerate

  assign blk16 = BW'(BW'(fy >> 4) * BW'(pw >> 5)) + BW'(fx >> 5);

  assign t32 = {blk32[BW-1:2], fx[3] ^ fy[4], fy[3], blk32[1:0],
                fx[4] ^ fy[2], fy[1:0], fx[2:0], 2'b00};
  assign t16 = {blk16[BW-1:2], fx[4] ^ fy[4], fy[3], blk16[1:0],
                fx[3], fy[2:0], fx[2:0], 1'b0};

  always_comb begin
    if (!tiled)     addr = lin;
    else if (fmt32) addr = t32;
    else            addr = t16;
  end
endmodule

// File: rtl/zs_field.sv
module zs_field
  import zs_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  input  logic               order_hi,
  input  logic               tgt_stencil,
  input  logic [DEPTH_W-1:0] val,
  output logic [WORD_W-1:0]  merged,
  output logic [DEPTH_W-1:0] field
);
  always_comb begin
    case ({order_hi, tgt_stencil})
      2'b00: begin
        merged = {word[31:24], val};
        field  = word[23:0];
      end
      2'b01: begin
        merged = {val[STEN_W-1:0], word[23:0]};
        field  = {16'h0, word[31:24]};
      end
      2'b10: begin
        merged = {val, word[7:0]};
        field  = word[31:8];
      end
      default: begin
        merged = {word[31:8], val[STEN_W-1:0]};
        field  = {16'h0, word[7:0]};
      end
    endcase
  end
endmodule

// File: rtl/zs_access_unit.sv
module zs_access_unit
  import zs_pkg::*;
#(
  parameter int CW          = 12,
  parameter int PW          = 12,
  parameter int AW          = 32,
  parameter bit NARROW_TILE = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_tgt_stencil,
  input  logic               req_fmt32,
  input  logic               req_order_hi,
  input  logic               req_tiled,
  input  logic [CW-1:0]      req_x,
  input  logic [CW-1:0]      req_y,
  input  logic [CW-1:0]      org_x,
  input  logic [CW-1:0]      org_y,
  input  logic [PW-1:0]      req_pitch,
  input  logic [DEPTH_W-1:0] req_wdata,
  output logic               rsp_valid,
  output logic [DEPTH_W-1:0] rsp_data,
  output logic               mem_req,
  input  logic               mem_ready,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [3:0]         mem_be,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic               mem_rvalid,
  input  logic [WORD_W-1:0]  mem_rdata
);
  zs_state_e          st;
  logic               op_we, op_16, op_ord, op_stn;
  logic [DEPTH_W-1:0] op_val;
  logic [AW-1:0]      gen_addr;
  logic [WORD_W-1:0]  mrg_word;
  logic [DEPTH_W-1:0] fld_val;
  logic [15:0]        half_val;

  zs_addr_gen #(.CW(CW), .PW(PW), .AW(AW), .NARROW_TILE(NARROW_TILE)) u_addr (
    .x(req_x), .y(req_y), .ox(org_x), .oy(org_y), .pitch(req_pitch),
    .fmt32(req_fmt32), .tiled(req_tiled), .addr(gen_addr)
  );

  zs_field u_field (
    .word(mem_rdata), .order_hi(op_ord), .tgt_stencil(op_stn),
    .val(op_val), .merged(mrg_word), .field(fld_val)
  );

  assign half_val  = mem_addr[1] ? mem_rdata[31:16] : mem_rdata[15:0];
  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st == ST_RD) || (st == ST_WR);
  assign mem_we    = (st == ST_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      op_we     <= 1'b0;
      op_16     <= 1'b0;
      op_ord    <= 1'b0;
      op_stn    <= 1'b0;
      op_val    <= '0;
      mem_addr  <= '0;
      mem_be    <= 4'h0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          op_we    <= req_write;
          op_16    <= !req_fmt32;
          op_ord   <= req_order_hi;
          op_stn   <= req_tgt_stencil;
          op_val   <= req_wdata;
          mem_addr <= gen_addr;
          if (req_fmt32) begin
            mem_be <= 4'hF;
            st     <= ST_RD;
          end else begin
            mem_be    <= gen_addr[1] ? 4'b1100 : 4'b0011;
            mem_wdata <= {req_wdata[15:0], req_wdata[15:0]};
            st        <= req_write ? ST_WR : ST_RD;
          end
        end
        ST_RD: if (mem_ready) st <= ST_RWAIT;
        ST_RWAIT: if (mem_rvalid) begin
          if (op_we) begin
            mem_wdata <= mrg_word;
            st        <= ST_WR;
          end else begin
            rsp_valid <= 1'b1;
            rsp_data  <= op_16 ? {8'h0, half_val} : fld_val;
            st        <= ST_IDLE;
          end
        end
        default: if (mem_ready) st <= ST_IDLE;
      endcase
    end
  end

  // bits the write-back must carry over unchanged from the word just read
  logic [WORD_W-1:0] keep_mask;
  assign keep_mask = op_stn ? (op_ord ? 32'hFFFF_FF00 : 32'h00FF_FFFF)
                            : (op_ord ? 32'h0000_00FF : 32'hFF00_0000);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R6
  rmw_writeback_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rvalid && !req_ready && !mem_req && op_we) |=>
      (mem_req && mem_we && $stable(mem_addr) && mem_be == 4'hF));

  // R6
  keep_field_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rvalid && !req_ready && !mem_req && op_we) |=>
      ((mem_wdata & keep_mask) == ($past(mem_rdata) & keep_mask)));

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R1
  addr_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (op_16 ? !mem_addr[0] : (mem_addr[1:0] == 2'b00)));
endmodule

// File: tb/zs_access_unit_tb.sv
`timescale 1ns/1ps
module zs_access_unit_tb_top;
  localparam int CW = 12, PW = 12, AW = 32;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic req_valid = 0, req_ready, req_write = 0, req_tgt_stencil = 0;
  logic req_fmt32 = 0, req_order_hi = 0, req_tiled = 0;
  logic [CW-1:0] req_x = 0, req_y = 0, org_x = 0, org_y = 0;
  logic [PW-1:0] req_pitch = 0;
  logic [23:0] req_wdata = 0, rsp_data;
  logic rsp_valid, mem_req, mem_ready, mem_we, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  zs_access_unit #(.CW(CW), .PW(PW), .AW(AW)) dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct packed { logic [31:0] a; logic we; logic [3:0] be; } mtx_t;
  mtx_t mq[$];
  logic [23:0] rq[$];
  logic [31:0] mem_m[int unsigned];
  logic [31:0] sh[int unsigned];

  function automatic logic [31:0] rd_m(int unsigned w);
    return mem_m.exists(w) ? mem_m[w] : 32'h0;
  endfunction
  function automatic logic [31:0] rd_sh(int unsigned w);
    return sh.exists(w) ? sh[w] : 32'h0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model with irregular stalls and one-cycle read latency
  logic [7:0] lfsr;
  always @(posedge clk) begin
    if (rst) begin
      lfsr <= 8'h5B; mem_ready <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready  <= lfsr[0] | lfsr[2];
      mem_rvalid <= 1'b0;
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          logic [31:0] w;
          w = rd_m(mem_addr >> 2);
          for (int b = 0; b < 4; b++) if (mem_be[b]) w[b*8 +: 8] = mem_wdata[b*8 +: 8];
          mem_m[mem_addr >> 2] = w;
        end else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= rd_m(mem_addr >> 2);
        end
      end
    end
  end

  // monitor: transactions, stall stability, read responses
  logic stalled = 0;
  logic [31:0] st_addr;
  logic st_we;
  always @(negedge clk) if (!rst && !done) begin
    if (stalled)
      chk(mem_req && mem_we == st_we && mem_addr == st_addr, "R10 request held", mem_addr, st_addr);
    stalled = mem_req && !mem_ready;
    st_addr = mem_addr; st_we = mem_we;
    if (mem_req && mem_ready) begin
      if (mq.size() == 0) chk(0, "R6 unexpected memory transaction", mem_addr, 0);
      else begin
        mtx_t e;
        e = mq.pop_front();
        chk(mem_addr == e.a, "R1/R2/R3/R4 address", mem_addr, e.a);
        chk(mem_we == e.we && mem_be == e.be, "R6/R8 kind and byte enables",
            {27'h0, mem_we, mem_be}, {27'h0, e.we, e.be});
      end
    end
    if (rsp_valid) begin
      if (rq.size() == 0) chk(0, "R7 unexpected response", {8'h0, rsp_data}, 0);
      else begin
        logic [23:0] e;
        e = rq.pop_front();
        chk(rsp_data == e, "R5/R7/R9 read data", {8'h0, rsp_data}, {8'h0, e});
      end
    end
  end

  function automatic logic [31:0] exp_addr(int x, int y, int ox, int oy, int p, bit f32, bit tl);
    int ax, ay, b;
    ax = x + ox; ay = y + oy;
    if (!tl) return (ax + ay * p) * (f32 ? 4 : 2);
    if (f32) begin
      b = (ay / 16) * (p / 16) + ax / 16;
      return (ax % 8) * 4 + (ay % 4) * 32 + (((ax >> 4) ^ (ay >> 2)) & 1) * 128 +
             (b % 4) * 256 + ((ay >> 3) & 1) * 1024 + (((ax >> 3) ^ (ay >> 4)) & 1) * 2048 +
             (b / 4) * 4096;
    end
    b = (ay / 16) * (p / 32) + ax / 32;
    return (ax % 8) * 2 + (ay % 8) * 16 + ((ax >> 3) & 1) * 128 + (b % 4) * 256 +
           ((ay >> 3) & 1) * 1024 + (((ax >> 4) ^ (ay >> 4)) & 1) * 2048 + (b / 4) * 4096;
  endfunction

  // driver: pushes expectations, then presents the request
  task automatic acc(bit wr, bit f32, bit tl, bit ohi, bit stn,
                     int x, int y, int ox, int oy, int p, logic [23:0] v);
    logic [31:0] a, w;
    mtx_t t;
    a = exp_addr(x, y, ox, oy, p, f32, tl);
    w = rd_sh(a >> 2);
    if (f32) begin
      t = '{a: a, we: 1'b0, be: 4'hF}; mq.push_back(t);
      if (wr) begin
        if (!ohi && !stn) w = (w & 32'hFF00_0000) | {8'h0, v};
        if (!ohi &&  stn) w = (w & 32'h00FF_FFFF) | {v[7:0], 24'h0};
        if ( ohi && !stn) w = (w & 32'h0000_00FF) | {v, 8'h0};
        if ( ohi &&  stn) w = (w & 32'hFFFF_FF00) | {24'h0, v[7:0]};
        sh[a >> 2] = w;
        t = '{a: a, we: 1'b1, be: 4'hF}; mq.push_back(t);
      end else if (!ohi) rq.push_back(stn ? {16'h0, w[31:24]} : w[23:0]);
      else               rq.push_back(stn ? {16'h0, w[7:0]} : w[31:8]);
    end else begin
      t = '{a: a, we: wr, be: a[1] ? 4'b1100 : 4'b0011}; mq.push_back(t);
      if (wr) begin
        if (a[1]) w[31:16] = v[15:0]; else w[15:0] = v[15:0];
        sh[a >> 2] = w;
      end else rq.push_back({8'h0, a[1] ? w[31:16] : w[15:0]});
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_fmt32 = f32; req_tiled = tl;
    req_order_hi = ohi; req_tgt_stencil = stn; req_x = CW'(x); req_y = CW'(y);
    org_x = CW'(ox); org_y = CW'(oy); req_pitch = PW'(p); req_wdata = v;
    @(negedge clk);
    req_valid = 0; req_wdata = 24'hDEAD00;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state while reset is held
    chk(req_ready && !mem_req && !rsp_valid, "R11 reset state",
        {29'h0, req_ready, mem_req, rsp_valid}, 32'h4);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !mem_req && !rsp_valid, "R11 after release",
        {29'h0, req_ready, mem_req, rsp_valid}, 32'h4);

    // R1 R2 R5 R6 R9: linear, depth low, same-word write then write then reads
    acc(1, 1, 0, 0, 0, 3, 2, 1, 1, 64, 24'hABCDEF);
    acc(1, 1, 0, 0, 1, 3, 2, 1, 1, 64, 24'h00005A);
    acc(0, 1, 0, 0, 0, 3, 2, 1, 1, 64, 0);
    acc(0, 1, 0, 0, 1, 3, 2, 1, 1, 64, 0);
    // R3 R5 R6: tiled, depth high, swizzle bits set both ways
    acc(1, 1, 1, 1, 0, 27, 23, 32, 16, 128, 24'h123456);
    acc(1, 1, 1, 1, 1, 27, 23, 32, 16, 128, 24'h0000C3);
    acc(0, 1, 1, 1, 0, 27, 23, 32, 16, 128, 0);
    acc(0, 1, 1, 1, 1, 27, 23, 32, 16, 128, 0);
    acc(1, 1, 1, 0, 1, 12, 6, 3, 9, 64, 24'hFFFF77);
    acc(0, 1, 1, 0, 0, 12, 6, 3, 9, 64, 0);
    // R4 R8: tiled 16-bit, both halves of a word, garbage in high write bits
    acc(1, 0, 1, 0, 0, 20, 28, 0, 0, 64, 24'hFFBEEF);
    acc(1, 0, 1, 0, 0, 21, 28, 0, 0, 64, 24'h771234);
    acc(0, 0, 1, 0, 0, 20, 28, 0, 0, 64, 0);
    acc(0, 0, 1, 0, 0, 21, 28, 0, 0, 64, 0);
    acc(1, 0, 1, 0, 0, 9, 19, 24, 5, 96, 24'h00A5A5);
    acc(0, 0, 1, 0, 0, 9, 19, 24, 5, 96, 0);
    // R1 R8: linear 16-bit
    acc(1, 0, 0, 0, 0, 5, 7, 2, 3, 64, 24'h33CAFE);
    acc(1, 0, 0, 0, 0, 6, 7, 2, 3, 64, 24'h440101);
    acc(0, 0, 0, 0, 0, 5, 7, 2, 3, 64, 0);
    acc(0, 0, 0, 0, 0, 6, 7, 2, 3, 64, 0);
    // sweep: R2 R3 R5 R6 R7 over many coordinates and modes
    for (int i = 0; i < 24; i++) begin
      int x, y, ox;
      bit tl, oh;
      x = (i * 13) % 50; y = (i * 7) % 40; ox = (i * 5) % 17;
      tl = i[0]; oh = i[1];
      acc(1, 1, tl, oh, 0, x, y, ox, 40, 64, 24'(i * 24'h01F3A7 + 24'h111111));
      acc(1, 1, tl, oh, 1, x, y, ox, 40, 64, 24'(i * 29 + 3));
      acc(0, 1, tl, oh, 0, x, y, ox, 40, 64, 0);
      acc(0, 1, tl, oh, 1, x, y, ox, 40, 64, 0);
    end
    repeat (20) @(negedge clk);
    chk(mq.size() == 0 && rq.size() == 0, "R6/R7 all expected traffic seen",
        mq.size() + rq.size(), 0);
    // R6: memory contents match the field-merge model word for word
    foreach (sh[k]) chk(rd_m(k) == sh[k], "R6 stored word", rd_m(k), sh[k]);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end
endmodule